// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR3 memory interface. It drives the memory's active-low reset, its clock enable and its command pins through the mandatory power-up ordering. The order is: hold reset, release reset with the clock enable still low, start the memory clock and let it settle, present a NOP, raise the clock enable, program the four mode registers, issue the long ZQ calibration, and wait out the DLL-lock and ZQ-init windows. After that it raises a completion flag and parks. Every wait is a parameter counted in system clock cycles. Where a rule needs the larger of an absolute time and a clock-cycle count, both figures are given as cycle parameters, and the larger one is chosen at elaboration.

A power-good input starts the sequence. If power-good drops at any point, the block goes back to its idle state on the next clock edge, with reset and clock enable low, and it starts the whole sequence again once power-good returns. The command output is a small code, and a separate field names the mode register that an MRS command targets.

Top module: `ddr3_init_seq`

## Requirements
- R1: While `arstN` is low, or while `pwrGood` has not yet been sampled high, `ddrResetN`=0, `ddrCke`=0, `memClkEn`=0, `initDone`=0 and `ddrCmd`=0. The command codes are 0 = NOP, 1 = MRS, 2 = ZQCL.
- R2: Counting from the first rising edge that samples `pwrGood` high, `ddrResetN` stays 0 for exactly max(RST_HOLD_CYC, CKE_PRE_CYC) cycles, with `ddrCke` low the whole time.
- R3: Once `ddrResetN` rises, `ddrCke` and `memClkEn` stay 0 for exactly CKE_WAIT_CYC cycles.
- R4: `memClkEn` then rises and stays high, with `ddrCke` still 0, for exactly max(CLK_STABLE_TIME_CYC, CLK_STABLE_NCK) cycles before the NOP cycle.
- R5: Exactly one cycle with `ddrCmd`=0, `ddrCke`=0 and `memClkEn`=1 comes next, and `ddrCke` rises on the cycle after it.
- R6: Starting on the cycle `ddrCke` rises, four MRS commands (`ddrCmd`=1) are issued MRD_CYC cycles apart. Their `ddrMrSel` values are 2, 3, 1, 0 in that order, each value being the mode register number.
- R7: A ZQCL command (`ddrCmd`=2) comes 4*MRD_CYC cycles after `ddrCke` rises and lasts one cycle. After it come exactly max(DLLK_CYC, ZQINIT_CYC) NOP cycles, and then `initDone` rises.
- R8: During the sequence, every cycle that carries no MRS or ZQCL command shows `ddrCmd`=0.
- R9: Once `ddrCke` has risen, it stays high through `initDone` and beyond for as long as `pwrGood` stays high.
- R10: If `pwrGood` is sampled low in any phase, then on the next cycle `ddrResetN`, `ddrCke`, `memClkEn` and `initDone` are 0 and `ddrCmd`=0. When `pwrGood` returns, the full sequence runs again with all its durations.
- R11: `initDone` is 1 only in the final parked state. Once set, it stays set while `pwrGood` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| arstN | input | 1 | Asynchronous active-low system reset |
| pwrGood | input | 1 | Supplies stable; a low level restarts the sequence |
| ddrResetN | output | 1 | Active-low memory reset |
| ddrCke | output | 1 | Memory clock enable |
| ddrCmd | output | 2 | Command code: 0 NOP, 1 MRS, 2 ZQCL |
| ddrMrSel | output | 2 | Mode register number for an MRS command |
| memClkEn | output | 1 | Request to run the memory clock |
| initDone | output | 1 | Initialization complete |

## Verification
The bench builds the expected level of every output for every cycle arithmetically from the phase lengths. It compares one uninterrupted power-up, with a parked tail, against the design cycle by cycle. The bench configuration makes two of the "larger of" minimums pick the absolute-time figure and one pick the cycle count, so a wrong choice in either direction changes a phase length. A sweep then withdraws power-good at every cycle offset from the first to just past completion. This separates a correct return to idle from one that leaks clock enable, the clock request or a stale command in any particular phase. It also shows whether the restart reproduces the full timeline rather than resuming part-way.

// File: rtl/ddr3i_pkg.sv
package ddr3i_pkg;

  typedef enum logic [3:0] {
    ST_WAIT_PWR,
    ST_RESET_HOLD,
    ST_CKE_LOW_WAIT,
    ST_CLK_STABLE,
    ST_NOP_CKE,
    ST_MRS_SEQ,
    ST_ZQINIT,
    ST_DLL_ZQ_WAIT,
    ST_DONE
  } seqState_t;

  typedef enum logic [2:0] {
    LD_RST,
    LD_CKE_WAIT,
    LD_CLK_STABLE,
    LD_MRD,
    LD_DLL_ZQ
  } loadSel_t;

  localparam logic [1:0] CMD_NOP  = 2'd0;
  localparam logic [1:0] CMD_MRS  = 2'd1;
  localparam logic [1:0] CMD_ZQCL = 2'd2;

  localparam int NUM_MR = 4;
  localparam int MR_W   = 2;

  // strobes from the control FSM to the timing datapath
  typedef struct packed {
    logic     load;
    loadSel_t loadSel;
    logic     mrClr;
    logic     mrAdv;
  } seqStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // programming order of the mode registers, step index -> register number
  function automatic logic [MR_W-1:0] mrOrder(input logic [MR_W-1:0] step);
    case (step)
      2'd0:    return 2'd2;
      2'd1:    return 2'd3;
      2'd2:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/ddr3i_timer.sv
module ddr3i_timer
  import ddr3i_pkg::*;
#(
  parameter int RST_HOLD_CYC        = 80000,
  parameter int CKE_PRE_CYC         = 4,
  parameter int CKE_WAIT_CYC        = 200000,
  parameter int CLK_STABLE_TIME_CYC = 4,
  parameter int CLK_STABLE_NCK      = 5,
  parameter int MRD_CYC             = 4,
  parameter int DLLK_CYC            = 512,
  parameter int ZQINIT_CYC          = 512
) (
  input  logic            clk,
  input  logic            arstN,
  input  seqStrobe_t      stb,
  output logic            cntZero,
  output logic            stepFresh,
  output logic            mrLast,
  output logic [MR_W-1:0] mrIdx
);

  // each minimum is the larger of its two figures, and never below one cycle
  localparam int RESET_LEN  = maxOf(maxOf(RST_HOLD_CYC, CKE_PRE_CYC), 1);
  localparam int CKEW_LEN   = maxOf(CKE_WAIT_CYC, 1);
  localparam int STABLE_LEN = maxOf(maxOf(CLK_STABLE_TIME_CYC, CLK_STABLE_NCK), 1);
  localparam int MRD_LEN    = maxOf(MRD_CYC, 1);
  localparam int DZ_LEN     = maxOf(maxOf(DLLK_CYC, ZQINIT_CYC), 1);
  localparam int LOAD_MAX   = maxOf(maxOf(maxOf(RESET_LEN, CKEW_LEN),
                                          maxOf(STABLE_LEN, MRD_LEN)), DZ_LEN);
  localparam int CNT_W      = $clog2(LOAD_MAX + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    case (stb.loadSel)
      LD_RST:        loadVal = CNT_W'(RESET_LEN - 1);
      LD_CKE_WAIT:   loadVal = CNT_W'(CKEW_LEN - 1);
      LD_CLK_STABLE: loadVal = CNT_W'(STABLE_LEN - 1);
      LD_MRD:        loadVal = CNT_W'(MRD_LEN - 1);
      default:       loadVal = CNT_W'(DZ_LEN - 1);
    endcase
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      cnt       <= '0;
      stepFresh <= 1'b0;
    end else begin
      stepFresh <= stb.load;
      if (stb.load) begin
        cnt <= loadVal;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      mrIdx <= '0;
    end else if (stb.mrClr) begin
      mrIdx <= '0;
    end else if (stb.mrAdv) begin
      mrIdx <= mrIdx + 1'b1;
    end
  end

  assign cntZero = (cnt == '0);
  assign mrLast  = (mrIdx == MR_W'(NUM_MR - 1));

  AST_MR_NO_WRAP: assert property (@(posedge clk) disable iff (!arstN)
    stb.mrAdv |-> !mrLast) else $error("mode register step advanced past the last"); // R6

  AST_LOAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!arstN)
    stb.mrAdv |-> (stb.load && stb.loadSel == LD_MRD)) else $error("step advance without spacing reload"); // R6

endmodule

// File: rtl/ddr3i_fsm.sv
module ddr3i_fsm
  import ddr3i_pkg::*;
(
  input  logic       clk,
  input  logic       arstN,
  input  logic       pwrGood,
  input  logic       cntZero,
  input  logic       stepFresh,
  input  logic       mrLast,
  output seqStrobe_t stb,
  output logic       ddrResetN,
  output logic       ddrCke,
  output logic       memClkEn,
  output logic       initDone,
  output logic [1:0] ddrCmd
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) state <= ST_WAIT_PWR;
    else        state <= nextState;
  end

  always_comb begin
    nextState   = state;
    stb.load    = 1'b0;
    stb.loadSel = LD_RST;
    stb.mrClr   = 1'b0;
    stb.mrAdv   = 1'b0;
    if (!pwrGood) begin
      nextState = ST_WAIT_PWR;
      stb.mrClr = 1'b1;
    end else begin
      case (state)
        ST_WAIT_PWR: begin
          nextState   = ST_RESET_HOLD;
          stb.load    = 1'b1;
          stb.loadSel = LD_RST;
        end
        ST_RESET_HOLD: if (cntZero) begin
          nextState   = ST_CKE_LOW_WAIT;
          stb.load    = 1'b1;
          stb.loadSel = LD_CKE_WAIT;
        end
        ST_CKE_LOW_WAIT: if (cntZero) begin
          nextState   = ST_CLK_STABLE;
          stb.load    = 1'b1;
          stb.loadSel = LD_CLK_STABLE;
        end
        ST_CLK_STABLE: if (cntZero) begin
          nextState = ST_NOP_CKE;
        end
        ST_NOP_CKE: begin
          nextState   = ST_MRS_SEQ;
          stb.load    = 1'b1;
          stb.loadSel = LD_MRD;
          stb.mrClr   = 1'b1;
        end
        ST_MRS_SEQ: if (cntZero) begin
          if (mrLast) begin
            nextState = ST_ZQINIT;
          end else begin
            stb.load    = 1'b1;
            stb.loadSel = LD_MRD;
            stb.mrAdv   = 1'b1;
          end
        end
        ST_ZQINIT: begin
          nextState   = ST_DLL_ZQ_WAIT;
          stb.load    = 1'b1;
          stb.loadSel = LD_DLL_ZQ;
        end
        ST_DLL_ZQ_WAIT: if (cntZero) begin
          nextState = ST_DONE;
        end
        ST_DONE: nextState = ST_DONE;
        default: nextState = ST_WAIT_PWR;
      endcase
    end
  end

  // Moore outputs decoded from the state register
  always_comb begin
    ddrResetN = !(state inside {ST_WAIT_PWR, ST_RESET_HOLD});
    ddrCke    = state inside {ST_MRS_SEQ, ST_ZQINIT, ST_DLL_ZQ_WAIT, ST_DONE};
    memClkEn  = state inside {ST_CLK_STABLE, ST_NOP_CKE, ST_MRS_SEQ,
                              ST_ZQINIT, ST_DLL_ZQ_WAIT, ST_DONE};
    initDone  = (state == ST_DONE);
    if (state == ST_MRS_SEQ && stepFresh) ddrCmd = CMD_MRS;
    else if (state == ST_ZQINIT)          ddrCmd = CMD_ZQCL;
    else                                  ddrCmd = CMD_NOP;
  end

  AST_PWR_LOSS_IDLE: assert property (@(posedge clk) disable iff (!arstN)
    !pwrGood |=> (!ddrResetN && !ddrCke && !memClkEn && !initDone && ddrCmd == CMD_NOP))
    else $error("power loss did not return to idle"); // R10

  AST_RST_RELEASE_CKE_LOW: assert property (@(posedge clk) disable iff (!arstN)
    $rose(ddrResetN) |-> !ddrCke) else $error("reset released with clock enable high"); // R2

  AST_NOP_BEFORE_CKE: assert property (@(posedge clk) disable iff (!arstN)
    $rose(ddrCke) |-> ($past(ddrCmd) == CMD_NOP && $past(memClkEn) && $past(ddrResetN)))
    else $error("clock enable rose without NOP and running clock"); // R5

  AST_CKE_HOLD: assert property (@(posedge clk) disable iff (!arstN)
    $fell(ddrCke) |-> !$past(pwrGood)) else $error("clock enable fell while power good"); // R9

  AST_CMD_NEEDS_CKE: assert property (@(posedge clk) disable iff (!arstN)
    (ddrCmd != CMD_NOP) |-> (ddrCke && ddrResetN)) else $error("command issued with clock enable low"); // R6

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!arstN)
    (initDone && pwrGood) |=> initDone) else $error("done flag dropped"); // R11

  AST_DONE_IMPLIES_CKE: assert property (@(posedge clk) disable iff (!arstN)
    initDone |-> (ddrCke && memClkEn && ddrCmd == CMD_NOP)) else $error("done with bad pin state"); // R11

endmodule

// File: rtl/ddr3_init_seq.sv
module ddr3_init_seq
  import ddr3i_pkg::*;
#(
  parameter int RST_HOLD_CYC        = 80000,
  parameter int CKE_PRE_CYC         = 4,
  parameter int CKE_WAIT_CYC        = 200000,
  parameter int CLK_STABLE_TIME_CYC = 4,
  parameter int CLK_STABLE_NCK      = 5,
  parameter int MRD_CYC             = 4,
  parameter int DLLK_CYC            = 512,
  parameter int ZQINIT_CYC          = 512
) (
  input  logic       clk,
  input  logic       arstN,
  input  logic       pwrGood,
  output logic       ddrResetN,
  output logic       ddrCke,
  output logic [1:0] ddrCmd,
  output logic [1:0] ddrMrSel,
  output logic       memClkEn,
  output logic       initDone
);

  seqStrobe_t      stb;
  logic            cntZero;
  logic            stepFresh;
  logic            mrLast;
  logic [MR_W-1:0] mrIdx;

  ddr3i_fsm u_fsm (
    .clk       (clk),
    .arstN     (arstN),
    .pwrGood   (pwrGood),
    .cntZero   (cntZero),
    .stepFresh (stepFresh),
    .mrLast    (mrLast),
    .stb       (stb),
    .ddrResetN (ddrResetN),
    .ddrCke    (ddrCke),
    .memClkEn  (memClkEn),
    .initDone  (initDone),
    .ddrCmd    (ddrCmd)
  );

  ddr3i_timer #(
    .RST_HOLD_CYC        (RST_HOLD_CYC),
    .CKE_PRE_CYC         (CKE_PRE_CYC),
    .CKE_WAIT_CYC        (CKE_WAIT_CYC),
    .CLK_STABLE_TIME_CYC (CLK_STABLE_TIME_CYC),
    .CLK_STABLE_NCK      (CLK_STABLE_NCK),
    .MRD_CYC             (MRD_CYC),
    .DLLK_CYC            (DLLK_CYC),
    .ZQINIT_CYC          (ZQINIT_CYC)
  ) u_timer (
    .clk       (clk),
    .arstN     (arstN),
    .stb       (stb),
    .cntZero   (cntZero),
    .stepFresh (stepFresh),
    .mrLast    (mrLast),
    .mrIdx     (mrIdx)
  );

  assign ddrMrSel = mrOrder(mrIdx);

endmodule

// File: tb/sim_ddr3_init_seq.sv
module sim_ddr3_init_seq;

  localparam int B_RST  = 20;
  localparam int B_PRE  = 25;
  localparam int B_CKEW = 30;
  localparam int B_CST  = 3;
  localparam int B_NCK  = 5;
  localparam int B_MRD  = 4;
  localparam int B_DLLK = 40;
  localparam int B_ZQ   = 60;

  localparam int E_RH   = (B_RST > B_PRE) ? B_RST : B_PRE;
  localparam int E_CS   = (B_CST > B_NCK) ? B_CST : B_NCK;
  localparam int E_DZ   = (B_DLLK > B_ZQ) ? B_DLLK : B_ZQ;
  localparam int E_BASE = E_RH + B_CKEW + E_CS + 1;
  localparam int E_TOT  = E_BASE + 4 * B_MRD + 1 + E_DZ;

  logic clk = 1'b0;
  logic arstN = 1'b0;
  logic pwrGood = 1'b0;
  logic ddrResetN, ddrCke, memClkEn, initDone;
  logic [1:0] ddrCmd, ddrMrSel;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  ddr3_init_seq #(
    .RST_HOLD_CYC (B_RST), .CKE_PRE_CYC (B_PRE), .CKE_WAIT_CYC (B_CKEW),
    .CLK_STABLE_TIME_CYC (B_CST), .CLK_STABLE_NCK (B_NCK), .MRD_CYC (B_MRD),
    .DLLK_CYC (B_DLLK), .ZQINIT_CYC (B_ZQ)
  ) u0 (
    .clk (clk), .arstN (arstN), .pwrGood (pwrGood), .ddrResetN (ddrResetN),
    .ddrCke (ddrCke), .ddrCmd (ddrCmd), .ddrMrSel (ddrMrSel),
    .memClkEn (memClkEn), .initDone (initDone)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      nFail = nFail + 1;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks = nChecks + 1;
    if (act != exp) begin
      nFail = nFail + 1;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int mrExp(input int step);
    case (step)
      0: return 2;
      1: return 3;
      2: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic idleCheck(input string tag);
    chk(tag, "ddrResetN", ddrResetN, 0);
    chk(tag, "ddrCke", ddrCke, 0);
    chk(tag, "memClkEn", memClkEn, 0);
    chk(tag, "initDone", initDone, 0);
    chk(tag, "ddrCmd", ddrCmd, 0);
  endtask

  // expected pins at offset i after the edge that first samples pwrGood high
  task automatic cmpCycle(input int i);
    int eR, eK, eC, eD, eCmd, eMr, j;
    string tag;
    eR = 1; eK = 0; eC = 0; eD = 0; eCmd = 0; eMr = -1;
    j = i - E_BASE;
    if (i < E_RH) begin
      eR = 0; tag = "R2";
    end else if (i < E_RH + B_CKEW) begin
      tag = "R3";
    end else if (i < E_RH + B_CKEW + E_CS) begin
      eC = 1; tag = "R4";
    end else if (i == E_BASE - 1) begin
      eC = 1; tag = "R5";
    end else if (j < 4 * B_MRD) begin
      eC = 1; eK = 1; tag = "R6";
      if (j % B_MRD == 0) begin
        eCmd = 1; eMr = mrExp(j / B_MRD);
      end
    end else if (j == 4 * B_MRD) begin
      eC = 1; eK = 1; eCmd = 2; tag = "R7";
    end else if (j < 4 * B_MRD + 1 + E_DZ) begin
      eC = 1; eK = 1; tag = "R7";
    end else begin
      eC = 1; eK = 1; eD = 1; tag = "R7";
    end
    chk(tag, "ddrResetN", ddrResetN, eR);
    chk((i >= E_BASE) ? "R9" : tag, "ddrCke", ddrCke, eK);
    chk(tag, "memClkEn", memClkEn, eC);
    chk("R11", "initDone", initDone, eD);
    chk((eCmd == 0) ? "R8" : tag, "ddrCmd", ddrCmd, eCmd);
    if (eMr >= 0) chk("R6", "ddrMrSel", ddrMrSel, eMr);
  endtask

  // called at a negedge; runs stopAt cycles then withdraws power
  task automatic runSeq(input int stopAt);
    pwrGood = 1'b1;
    for (int i = 0; i < stopAt; i++) begin
      @(negedge clk);
      cmpCycle(i);
    end
    pwrGood = 1'b0;
    @(negedge clk);
    idleCheck("R10");
    @(negedge clk);
    idleCheck("R1");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    idleCheck("R1");
    arstN = 1'b1;
    repeat (3) begin
      @(negedge clk);
      idleCheck("R1");
    end
    runSeq(E_TOT + 20);
    for (int d = 1; d <= E_TOT + 2; d++) begin
      runSeq(d);
    end
    runSeq(E_TOT + 5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule